// File: doc/BRIEF.md
# UART Receiver with Status-Tagged FIFO

This block receives asynchronous serial characters from a single input line and hands them to the rest of the chip as parallel words. A free-running tick at sixteen times the bit rate paces the receiver. After a falling edge it confirms the start bit at the middle of the bit. It then samples every later bit at its centre and rebuilds a character of 5, 6, 7 or 8 data bits. An optional parity bit and one or two stop bits may follow the data.

Each finished character goes into a small receive FIFO as a 12-bit word. The data sits in the low byte, and four error flags sit above it: framing, parity, break and overrun. Because every entry carries its own flags, a consumer that pops the FIFO knows exactly which character went wrong, with no shared status register to clear. The FIFO is show-ahead: the oldest word is always present on the read port, and a one-cycle pop strobe removes it.

The frame format comes from static configuration inputs. They are meant to be changed only while the line is idle. The reset input is asserted asynchronously and released synchronously inside the block. The serial input passes through a synchronizer before it is used.

Top module: `uart_rx_statq`

## Requirements
- R1: A low level seen on a tick while idle is accepted as a start bit only if the line is still low 8 ticks later; a low pulse shorter than that stores nothing and the receiver returns to idle.
- R2: Data bits are sampled every 16 ticks after the start-bit centre, least significant bit first, and an 8-bit frame with no parity and one stop bit stores its data in bits [7:0] with bits [11:8] zero.
- R3: cfg_len_i selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Shorter characters are stored zero-extended in bits [7:0].
- R4: With cfg_par_en_i high, one parity bit follows the data. cfg_par_odd_i = 0 selects even parity and 1 selects odd parity. A mismatch sets bit 9 of the stored word.
- R5: cfg_stop2_i selects one (0) or two (1) stop bits. Any stop bit sampled low sets bit 8. After such a frame, no new start bit is looked for until the line has been seen high.
- R6: A frame in which every sampled bit, stop bits included, is low is stored as exactly one word 12'h500: break (bit 10) and framing (bit 8) set, parity flag and data zero.
- R7: The FIFO holds FIFO_DEPTH words (16 by default) in arrival order. rdata_o shows the oldest word while empty_o is low. pop_i removes one word and is ignored when empty_o is high.
- R8: A character that completes while the FIFO is full, with no pop in that cycle, is discarded, and bit 11 (overrun) of the most recently stored word is set.
- R9: After reset the FIFO is empty (empty_o high) and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_i | input | 1 | Serial receive line, idle high |
| tick16_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_len_i | input | 2 | Data length select, 0..3 for 5..8 bits |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_stop2_i | input | 1 | 1 selects two stop bits |
| pop_i | input | 1 | Remove the oldest FIFO word |
| rdata_o | output | 12 | Oldest word: {overrun, break, parity, framing, data[7:0]} |
| empty_o | output | 1 | FIFO holds no word |

## Verification
The bench builds the block with FIFO_DEPTH = 4 and the default 16x oversampling, and pulses the tick every fourth clock. With the shallow FIFO, the full condition and the overrun tag on the newest entry are reached after five characters. That leaves enough cycle budget for every data length, both parity senses, a bad second stop bit, a long break and a short start glitch.

// File: rtl/uart_rx_statq_pkg.sv
package uart_rx_statq_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PARITY,
    RX_STOP,
    RX_HOLD
  } rx_state_e;

  localparam int unsigned DATA_W  = 8;
  localparam int unsigned WORD_W  = DATA_W + 4;
  localparam int unsigned BIT_OVR = DATA_W + 3;
  localparam int unsigned BIT_BRK = DATA_W + 2;
  localparam int unsigned BIT_PAR = DATA_W + 1;
  localparam int unsigned BIT_FRM = DATA_W;

endpackage

// File: rtl/rxq_sync.sv
module rxq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= RST_VAL;
    else        stage_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= RST_VAL;
      else        stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/rxq_frame.sv
module rxq_frame
  import uart_rx_statq_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic [1:0]        cfg_len_i,
  input  logic              cfg_par_en_i,
  input  logic              cfg_par_odd_i,
  input  logic              cfg_stop2_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o
);

  localparam int unsigned CW  = $clog2(OSR);
  localparam int unsigned BIW = $clog2(DATA_W);
  localparam logic [CW-1:0]  MID_CNT  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0]  LAST_CNT = CW'(OSR - 1);
  localparam logic [BIW-1:0] MIN_IDX  = BIW'(DATA_W - 4);

  rx_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BIW-1:0]    bit_q, bit_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              par_q, par_d;
  logic              seen_q, seen_d;
  logic              perr_q, perr_d;
  logic              ferr_q, ferr_d;
  logic              stop2_q, stop2_d;
  logic              ferr_now, seen_now;
  logic [BIW-1:0]    last_idx;

  assign last_idx = MIN_IDX + BIW'(cfg_len_i);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    bit_d    = bit_q;
    data_d   = data_q;
    par_d    = par_q;
    seen_d   = seen_q;
    perr_d   = perr_q;
    ferr_d   = ferr_q;
    stop2_d  = stop2_q;
    push_o   = 1'b0;
    word_o   = '0;
    ferr_now = ferr_q | ~rx_i;
    seen_now = seen_q | rx_i;
    if (tick_i) begin
      case (state_q)
        RX_IDLE: begin
          if (!rx_i) begin
            state_d = RX_START;
            cnt_d   = '0;
          end
        end
        RX_START: begin
          if (cnt_q == MID_CNT) begin
            cnt_d = '0;
            if (rx_i) begin
              state_d = RX_IDLE;
            end else begin
              state_d = RX_DATA;
              bit_d   = '0;
              data_d  = '0;
              par_d   = 1'b0;
              seen_d  = 1'b0;
              perr_d  = 1'b0;
              ferr_d  = 1'b0;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d          = '0;
            data_d[bit_q]  = rx_i;
            par_d          = par_q ^ rx_i;
            seen_d         = seen_now;
            if (bit_q == last_idx) begin
              state_d = cfg_par_en_i ? RX_PARITY : RX_STOP;
              stop2_d = cfg_stop2_i;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_PARITY: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d   = '0;
            perr_d  = (par_q ^ rx_i) != cfg_par_odd_i;
            seen_d  = seen_now;
            state_d = RX_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d  = '0;
            ferr_d = ferr_now;
            seen_d = seen_now;
            if (stop2_q) begin
              stop2_d = 1'b0;
            end else begin
              push_o = 1'b1;
              if (!seen_now) begin
                word_o[BIT_BRK] = 1'b1;
                word_o[BIT_FRM] = 1'b1;
              end else begin
                word_o[BIT_PAR]      = perr_q;
                word_o[BIT_FRM]      = ferr_now;
                word_o[DATA_W-1:0]   = data_q;
              end
              state_d = ferr_now ? RX_HOLD : RX_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_HOLD: begin
          if (rx_i) state_d = RX_IDLE;
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      data_q  <= '0;
      par_q   <= 1'b0;
      seen_q  <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      stop2_q <= 1'b0;
    end else if (tick_i) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      data_q  <= data_d;
      par_q   <= par_d;
      seen_q  <= seen_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
      stop2_q <= stop2_d;
    end
  end

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int unsigned W     = 12,
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic [W-1:0]               wdata_i,
  input  logic                       pop_i,
  output logic [W-1:0]               rdata_o,
  output logic                       empty_o,
  output logic                       full_o,
  output logic [$clog2(DEPTH):0]     level_o
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW-1:0] TOP_IDX = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULL_LV = (AW + 1)'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d, newest;
  logic [AW:0]   lvl_q, lvl_d;
  logic          do_push, do_pop, mark_ovr;

  assign empty_o  = (lvl_q == '0);
  assign full_o   = (lvl_q == FULL_LV);
  assign level_o  = lvl_q;
  assign rdata_o  = mem_q[rd_q];
  assign do_pop   = pop_i & ~empty_o;
  assign do_push  = push_i & (~full_o | do_pop);
  assign mark_ovr = push_i & full_o & ~do_pop;
  assign newest   = (wr_q == '0) ? TOP_IDX : wr_q - 1'b1;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    if (do_push) wr_d = (wr_q == TOP_IDX) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == TOP_IDX) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      lvl_d = lvl_q + 1'b1;
    else if (do_pop && !do_push) lvl_d = lvl_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push)  mem_q[wr_q]         <= wdata_i;
    if (mark_ovr) mem_q[newest][W-1]  <= 1'b1;
  end

endmodule

// File: rtl/uart_rx_statq.sv
module uart_rx_statq
  import uart_rx_statq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 16,
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              tick16_i,
  input  logic [1:0]        cfg_len_i,
  input  logic              cfg_par_en_i,
  input  logic              cfg_par_odd_i,
  input  logic              cfg_stop2_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              empty_o
);

  logic                        rst_s;
  logic                        rx_s;
  logic                        push;
  logic [WORD_W-1:0]           push_word;
  logic                        full;
  logic [$clog2(FIFO_DEPTH):0] level;

  rxq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_s)
  );

  rxq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst_n(rst_s), .d_i(rx_i), .q_o(rx_s)
  );

  rxq_frame #(.OSR(OSR)) u_frame (
    .clk(clk), .rst_n(rst_s), .tick_i(tick16_i), .rx_i(rx_s),
    .cfg_len_i(cfg_len_i), .cfg_par_en_i(cfg_par_en_i),
    .cfg_par_odd_i(cfg_par_odd_i), .cfg_stop2_i(cfg_stop2_i),
    .push_o(push), .word_o(push_word)
  );

  rxq_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_s), .push_i(push), .wdata_i(push_word),
    .pop_i(pop_i), .rdata_o(rdata_o), .empty_o(empty_o),
    .full_o(full), .level_o(level)
  );

endmodule

// File: rtl/uart_rx_statq_chk.sv
module uart_rx_statq_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick,
  input logic                   push,
  input logic [11:0]            word,
  input logic                   pop,
  input logic                   empty,
  input logic                   full,
  input logic [$clog2(DEPTH):0] level
);

  localparam int unsigned LW = $clog2(DEPTH) + 1;

  AST_PUSH_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> tick); // R2

  AST_BREAK_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (push && word[10]) |-> (word[7:0] == 8'h00 && word[8] && !word[9])); // R6

  AST_NO_OVR_AT_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !word[11]); // R8

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R7

  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty); // R7

  AST_FULL_ON_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full); // R8

endmodule

bind uart_rx_statq uart_rx_statq_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_s), .tick(tick16_i), .push(push),
  .word(push_word), .pop(pop_i), .empty(empty_o), .full(full),
  .level(level)
);

// File: tb/uart_rx_statq_tb.sv
module uart_rx_statq_tb;

  localparam int DEPTH  = 4;
  localparam int CPT    = 4;
  localparam int BITCLK = 16 * CPT;

  logic        clk = 1'b0;
  logic        rst_n, rx, tick, pop;
  logic [1:0]  cfg_len;
  logic        cfg_pe, cfg_po, cfg_s2;
  logic [11:0] rdata;
  logic        empty;
  int          tick_cnt = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tick_cnt <= (tick_cnt == CPT - 1) ? 0 : tick_cnt + 1;
    tick     <= (tick_cnt == CPT - 1);
  end

  uart_rx_statq #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick16_i(tick),
    .cfg_len_i(cfg_len), .cfg_par_en_i(cfg_pe), .cfg_par_odd_i(cfg_po),
    .cfg_stop2_i(cfg_s2), .pop_i(pop), .rdata_o(rdata), .empty_o(empty)
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int nbits);
    rx = v;
    repeat (nbits * BITCLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] len, input logic pe,
                      input logic po, input logic s2, input logic badp,
                      input logic [1:0] stoplow);
    logic [7:0] mask;
    mask = 8'hFF >> (2'd3 - len);
    cfg_len = len; cfg_pe = pe; cfg_po = po; cfg_s2 = s2;
    hold_line(1'b0, 1);
    for (int i = 0; i < 5 + int'(len); i++) hold_line(d[i], 1);
    if (pe) hold_line((^(d & mask)) ^ po ^ badp, 1);
    hold_line(~stoplow[0], 1);
    if (s2) hold_line(~stoplow[1], 1);
    hold_line(1'b1, 2);
  endtask

  task automatic pop_expect(input string req, input logic [11:0] exp);
    check({req, " not empty"}, {11'b0, empty}, 12'h000);
    check(req, rdata, exp);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_empty(input string req);
    check({req, " empty"}, {11'b0, empty}, 12'h001);
  endtask

  task automatic t_reset;
    expect_empty("R9 reset");
  endtask

  task automatic t_basic;
    send(8'hA5, 2'd3, 0, 0, 0, 0, 2'b00);
    send(8'h3C, 2'd3, 0, 0, 0, 0, 2'b00);
    pop_expect("R2 8N1 first", 12'h0A5);
    pop_expect("R2 8N1 second", 12'h03C);
    expect_empty("R7 drained");
  endtask

  task automatic t_lengths;
    send(8'hFF, 2'd0, 0, 0, 0, 0, 2'b00);
    pop_expect("R3 5-bit zero-extend", 12'h01F);
    send(8'h2A, 2'd1, 0, 0, 0, 0, 2'b00);
    pop_expect("R3 6-bit", 12'h02A);
    send(8'h15, 2'd0, 0, 0, 0, 0, 2'b00);
    pop_expect("R3 5-bit pattern", 12'h015);
  endtask

  task automatic t_parity;
    send(8'h55, 2'd2, 1, 0, 0, 0, 2'b00);
    pop_expect("R4 even good", 12'h055);
    send(8'h55, 2'd2, 1, 0, 0, 1, 2'b00);
    pop_expect("R4 even bad", 12'h255);
    send(8'h33, 2'd1, 1, 1, 0, 0, 2'b00);
    pop_expect("R4 odd good", 12'h033);
    send(8'h33, 2'd1, 1, 1, 0, 1, 2'b00);
    pop_expect("R4 odd bad", 12'h233);
  endtask

  task automatic t_stop;
    send(8'h81, 2'd3, 0, 0, 0, 0, 2'b01);
    pop_expect("R5 stop low", 12'h181);
    expect_empty("R5 no false start");
    send(8'h6C, 2'd3, 0, 0, 1, 0, 2'b10);
    pop_expect("R5 second stop low", 12'h16C);
    send(8'h6C, 2'd3, 0, 0, 1, 0, 2'b00);
    pop_expect("R5 two stops good", 12'h06C);
  endtask

  task automatic t_break;
    cfg_len = 2'd3; cfg_pe = 0; cfg_po = 0; cfg_s2 = 0;
    hold_line(1'b0, 14);
    hold_line(1'b1, 2);
    pop_expect("R6 break word", 12'h500);
    expect_empty("R6 single entry");
  endtask

  task automatic t_glitch;
    rx = 1'b0;
    repeat (3 * CPT) @(negedge clk);
    hold_line(1'b1, 2);
    expect_empty("R1 glitch rejected");
    send(8'hC3, 2'd3, 0, 0, 0, 0, 2'b00);
    pop_expect("R1 frame after glitch", 12'h0C3);
  endtask

  task automatic t_empty_pop;
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    expect_empty("R7 pop on empty");
    send(8'h5A, 2'd3, 0, 0, 0, 0, 2'b00);
    pop_expect("R7 pop on empty ignored", 12'h05A);
  endtask

  task automatic t_overrun;
    for (int i = 0; i < DEPTH + 1; i++)
      send(8'(8'h11 + i), 2'd3, 0, 0, 0, 0, 2'b00);
    pop_expect("R8 entry 0", 12'h011);
    pop_expect("R8 entry 1", 12'h012);
    pop_expect("R8 entry 2", 12'h013);
    pop_expect("R8 newest tagged", 12'h814);
    expect_empty("R8 extra discarded");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx = 1'b1; pop = 1'b0; tick = 1'b0;
    cfg_len = 2'd3; cfg_pe = 1'b0; cfg_po = 1'b0; cfg_s2 = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic();
    t_lengths();
    t_parity();
    t_stop();
    t_break();
    t_glitch();
    t_empty_pop();
    t_overrun();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule